// File: doc/BRIEF.md
# ECC-protected local memory slave

This block is a single-clock memory slave for a simple processor-side local memory bus. A master raises a request strobe with a word address, a read/write flag, four byte-lane enables and write data. The slave answers with a one-cycle completion pulse, `ready_o`. Before that pulse it can raise `wait_o` to say the transfer has been accepted but is still running.

Every stored 32-bit word carries 7 check bits of an extended Hamming code. With this code the slave corrects any single flipped bit in the codeword and detects any two flipped bits. On a read, the returned word is the corrected value. A correctable error sets `ce_o` and an uncorrectable one sets `ue_o`, both only in the completion cycle.

A full-word write is encoded and stored in one cycle. A byte or halfword write is a read-modify-write: the old word is read and corrected while `wait_o` is high, the enabled lanes are merged in, and the result is stored with fresh check bits. The completion flags of that write describe the old word. An injection port XORs a mask into any stored codeword so that errors can be provoked on purpose.

Top module: `ecc_mem_slave`

## Requirements
- R1: After reset `ready_o`, `wait_o`, `ce_o` and `ue_o` are low, and every word reads back as zero with no error flag.
- R2: A read accepted at a rising edge gives `ready_o` high in the next cycle with `rdata_o` valid, and `wait_o` stays low throughout.
- R3: A write with all four enables set (`be_i` = 4'hF) gives `ready_o` in the next cycle without `wait_o`, with `ce_o` = `ue_o` = 0, and the word is stored with fresh check bits.
- R4: A write with any enable clear gives exactly one cycle of `wait_o`, then `ready_o`. Bit i of `be_i` selects data bits 8i+7..8i to be replaced, and the other lanes keep the corrected old value.
- R5: A read of a word with one flipped codeword bit returns the corrected data with `ce_o` = 1 and `ue_o` = 0. The stored word is left as it is.
- R6: A read of a word with two flipped codeword bits gives `ue_o` = 1 and `ce_o` = 0. `ce_o` and `ue_o` are never high together.
- R7: A partial write reports in its `ready_o` cycle `ce_o`/`ue_o` for the old stored word. After a correctable partial write the word reads back clean.
- R8: `ce_o` and `ue_o` are low in every cycle where `ready_o` is low.
- R9: A request presented while `wait_o` is high is ignored and leaves memory untouched.
- R10: With `inj_en_i` high, `inj_mask_i` (bit 0 the overall parity, bits 1..38 the Hamming positions) is XORed into the codeword at `inj_addr_i` at the next edge. If a write stores to the same word in that same edge, the mask applies on top of the new codeword.
- R11: `ready_o` and `wait_o` are never high together, and `ready_o` rises only after an accepted request or a wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| be_i | input | 4 | Byte-lane write enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Corrected read data, valid with `ready_o` |
| ready_o | output | 1 | Transfer complete |
| wait_o | output | 1 | Transfer accepted, not yet complete |
| ce_o | output | 1 | Correctable error, valid with `ready_o` |
| ue_o | output | 1 | Uncorrectable error, valid with `ready_o` |
| inj_en_i | input | 1 | Apply error mask this edge |
| inj_addr_i | input | ADDR_W | Word address for error mask |
| inj_mask_i | input | 39 | Codeword bits to flip |

## Verification
A store from the bus and an error injection can hit the same word at the same rising edge. The bench provokes this directly: in one cycle it issues a full-word write and sets a single-bit mask for the same address. A following read must then give the new data with `ce_o` set, which shows the mask landed on the freshly encoded codeword and not on the old one. During the random phase, injections are only placed between transfers, so the bench model's count of flipped bits per word stays exact.

// File: rtl/ecc_slave_pkg.sv
package ecc_slave_pkg;
  localparam int DATA_W  = 32;
  localparam int NBYTES  = DATA_W / 8;
  localparam int HAM_CHK = 6;
  localparam int CW_W    = DATA_W + HAM_CHK + 1;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic {ST_IDLE, ST_MERGE} slv_state_e;

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_slave_pkg::*;
(
  input  word_t data_i,
  output cw_t   cw_o
);
  always_comb begin
    cw_t c;
    int  j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = data_i[j];
        j++;
      end
    end
    for (int i = 0; i < HAM_CHK; i++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW_W; p++)
        if (p[i] && !is_pow2(p)) x ^= c[p];
      c[1 << i] = x;
    end
    c[0] = ^c[CW_W-1:1];
    cw_o = c;
  end
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_slave_pkg::*;
(
  input  cw_t   cw_i,
  output word_t data_o,
  output logic  ce_o,
  output logic  ue_o
);
  logic [HAM_CHK-1:0] syn;
  logic               par;
  logic               hit;
  cw_t                fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++)
      if (cw_i[p]) syn ^= p[HAM_CHK-1:0];
    par = ^cw_i;
  end

  always_comb begin
    fixed = cw_i;
    hit   = 1'b0;
    ce_o  = 1'b0;
    ue_o  = 1'b0;
    if (par) begin
      // odd parity: single error at position syn (0 = parity bit itself)
      for (int p = 0; p < CW_W; p++) begin
        if (syn == p[HAM_CHK-1:0]) begin
          fixed[p] = ~cw_i[p];
          hit      = 1'b1;
        end
      end
      ce_o = hit;
      ue_o = !hit;
    end else if (syn != '0) begin
      ue_o = 1'b1;
    end
  end

  always_comb begin
    int j;
    j = 0;
    data_o = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        data_o[j] = fixed[p];
        j++;
      end
    end
  end
endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_slave_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output cw_t               rd_cw_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  cw_t               wr_cw_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  cw_t               inj_mask_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  cw_t words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic wr_hit, inj_hit;
    cw_t  base, word_q;

    assign wr_hit  = wr_en_i && (wr_addr_i == ADDR_W'(g));
    assign inj_hit = inj_en_i && (inj_addr_i == ADDR_W'(g));
    assign base    = wr_hit ? wr_cw_i : word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               word_q <= '0;
      else if (wr_hit || inj_hit) word_q <= base ^ (inj_hit ? inj_mask_i : '0);
    end

    assign words[g] = word_q;
  end

  assign rd_cw_o = words[rd_addr_i];
endmodule

// File: rtl/ecc_mem_slave.sv
module ecc_mem_slave
  import ecc_slave_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              wait_o,
  output logic              ce_o,
  output logic              ue_o,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [38:0]       inj_mask_i
);
  slv_state_e        st_q;
  logic              idle, accept, full_wr, part_wr, rd_acc, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  word_t             wr_data, merged, dec_data;
  cw_t               wr_cw, rd_cw;
  logic              dec_ce, dec_ue;

  logic [ADDR_W-1:0] hold_addr_q;
  logic [NBYTES-1:0] hold_be_q;
  word_t             hold_wdata_q, hold_old_q, rdata_q;
  logic              hold_ce_q, hold_ue_q, ready_q, ce_q, ue_q;

  assign idle    = (st_q == ST_IDLE);
  assign accept  = idle && req_i;
  assign full_wr = accept && we_i && (&be_i);
  assign part_wr = accept && we_i && !(&be_i);
  assign rd_acc  = accept && !we_i;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = hold_be_q[b] ? hold_wdata_q[8*b +: 8] : hold_old_q[8*b +: 8];
  end

  assign wr_en   = full_wr || !idle;
  assign wr_addr = idle ? addr_i : hold_addr_q;
  assign wr_data = idle ? wdata_i : merged;

  ecc_encode i_enc (
    .data_i (wr_data),
    .cw_o   (wr_cw)
  );

  ecc_store #(.ADDR_W(ADDR_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (addr_i),
    .rd_cw_o    (rd_cw),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_cw_i    (wr_cw),
    .inj_en_i   (inj_en_i),
    .inj_addr_i (inj_addr_i),
    .inj_mask_i (inj_mask_i)
  );

  ecc_decode i_dec (
    .cw_i   (rd_cw),
    .data_o (dec_data),
    .ce_o   (dec_ce),
    .ue_o   (dec_ue)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      hold_addr_q  <= '0;
      hold_be_q    <= '0;
      hold_wdata_q <= '0;
      hold_old_q   <= '0;
      hold_ce_q    <= 1'b0;
      hold_ue_q    <= 1'b0;
      rdata_q      <= '0;
      ready_q      <= 1'b0;
      ce_q         <= 1'b0;
      ue_q         <= 1'b0;
    end else begin
      st_q    <= part_wr ? ST_MERGE : ST_IDLE;
      ready_q <= rd_acc || full_wr || !idle;
      ce_q    <= (rd_acc && dec_ce) || (!idle && hold_ce_q);
      ue_q    <= (rd_acc && dec_ue) || (!idle && hold_ue_q);
      if (rd_acc) rdata_q <= dec_data;
      if (part_wr) begin
        hold_addr_q  <= addr_i;
        hold_be_q    <= be_i;
        hold_wdata_q <= wdata_i;
        hold_old_q   <= dec_data;
        hold_ce_q    <= dec_ce;
        hold_ue_q    <= dec_ue;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = ready_q;
  assign wait_o  = !idle;
  assign ce_o    = ce_q;
  assign ue_o    = ue_q;
endmodule

// File: rtl/ecc_mem_slave_chk.sv
module ecc_mem_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [3:0] be_i,
  input logic       ready_o,
  input logic       wait_o,
  input logic       ce_o,
  input logic       ue_o
);
  assert_read_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !wait_o) |=> (ready_o && !wait_o));

  assert_full_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (be_i == 4'hF) && !wait_o) |=> (ready_o && !wait_o && !ce_o && !ue_o));

  assert_partial_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (be_i != 4'hF) && !wait_o) |=> (wait_o && !ready_o));

  assert_wait_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> (ready_o && !wait_o));

  assert_ce_ue_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && ue_o));

  assert_flags_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!ce_o && !ue_o));

  assert_req_in_wait_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && req_i) |=> !wait_o);

  assert_ready_wait_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && wait_o));

  assert_ready_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(req_i && !wait_o) || $past(wait_o)));
endmodule

bind ecc_mem_slave ecc_mem_slave_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .be_i    (be_i),
  .ready_o (ready_o),
  .wait_o  (wait_o),
  .ce_o    (ce_o),
  .ue_o    (ue_o)
);

// File: tb/test_ecc_mem_slave.sv
module test_ecc_mem_slave;
  localparam int unsigned AW = 6;
  localparam int NA = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ready, wt, ce, ue;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [38:0]   inj_mask = '0;

  int checks = 0, fails = 0;
  logic [31:0] m_data  [NA];
  logic [38:0] m_flip  [NA];
  bit          m_dirty [NA];

  always #10 clk = ~clk;

  ecc_mem_slave #(.ADDR_W(AW)) i_ecc_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .wait_o(wt), .ce_o(ce), .ue_o(ue), .inj_en_i(inj_en),
    .inj_addr_i(inj_addr), .inj_mask_i(inj_mask)
  );

  function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = b[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_check();
    check(ready === 1'b0 && wt === 1'b0 && ce === 1'b0 && ue === 1'b0,
          "R8 idle outputs quiet", {28'b0, ready, wt, ce, ue}, 32'h0);
  endtask

  task automatic do_read(input int a);
    int n;
    n = $countones(m_flip[a]);
    @(negedge clk); idle_check();
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk); req = 1'b0;
    check(ready === 1'b1 && wt === 1'b0, "R2 read ready without wait", {30'b0, ready, wt}, 32'h2);
    if (n == 0) begin
      check(ce === 1'b0 && ue === 1'b0, "R2 read flags clean", {30'b0, ce, ue}, 32'h0);
      if (!m_dirty[a]) check(rdata === m_data[a], "R2 read data", rdata, m_data[a]);
    end else if (n == 1) begin
      check(ce === 1'b1 && ue === 1'b0, "R5 single error flags", {30'b0, ce, ue}, 32'h2);
      if (!m_dirty[a]) check(rdata === m_data[a], "R5 corrected data", rdata, m_data[a]);
    end else begin
      check(ce === 1'b0 && ue === 1'b1, "R6 double error flags", {30'b0, ce, ue}, 32'h1);
    end
  endtask

  task automatic do_write(input int a, input logic [3:0] b, input logic [31:0] d,
                          input bit poke, input logic [38:0] imask);
    int n;
    n = $countones(m_flip[a]);
    @(negedge clk); idle_check();
    req = 1'b1; we = 1'b1; addr = AW'(a); be = b; wdata = d;
    if (imask != '0) begin inj_en = 1'b1; inj_addr = AW'(a); inj_mask = imask; end
    if (b == 4'hF) begin
      @(negedge clk); req = 1'b0; inj_en = 1'b0;
      check(ready === 1'b1 && wt === 1'b0 && ce === 1'b0 && ue === 1'b0,
            "R3 full write completion", {28'b0, ready, wt, ce, ue}, 32'h8);
      m_data[a] = d; m_flip[a] = imask; m_dirty[a] = 1'b0;
    end else begin
      @(negedge clk);
      check(wt === 1'b1 && ready === 1'b0, "R4 partial write wait", {30'b0, ready, wt}, 32'h1);
      if (poke) begin
        req = 1'b1; we = 1'b1; be = 4'hF; addr = AW'((a + 1) % NA); wdata = ~d;
      end else req = 1'b0;
      @(negedge clk); req = 1'b0;
      check(ready === 1'b1 && wt === 1'b0, "R4 partial write ready", {30'b0, ready, wt}, 32'h2);
      check(ce === (n == 1) && ue === (n >= 2), "R7 partial write old-word flags",
            {30'b0, ce, ue}, {30'b0, n == 1, n >= 2});
      if (n >= 2) m_dirty[a] = 1'b1;
      else m_data[a] = merge(m_data[a], d, b);
      m_flip[a] = '0;
    end
  endtask

  task automatic inject(input int a, input logic [38:0] mask);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = AW'(a); inj_mask = mask;
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
    m_flip[a] ^= mask;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r;
    void'($urandom(32'h5EED_0C0D));
    for (int i = 0; i < NA; i++) begin m_data[i] = '0; m_flip[i] = '0; m_dirty[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b0 && wt === 1'b0 && ce === 1'b0 && ue === 1'b0,
          "R1 reset outputs", {28'b0, ready, wt, ce, ue}, 32'h0);
    do_read(5);
    check(rdata === 32'h0 && ce === 1'b0 && ue === 1'b0, "R1 reset memory zero", rdata, 32'h0);

    for (int i = 0; i < NA; i++) do_write(i, 4'hF, $urandom, 1'b0, '0);
    for (int i = 0; i < NA; i++) do_read(i);

    inject(1, 39'h1 << 17);
    do_read(1);
    do_read(1); // R5: still flagged, no scrub on read
    inject(2, (39'h1 << 3) | (39'h1 << 30));
    do_read(2);
    inject(4, 39'h1);
    do_read(4);

    do_write(1, 4'b0011, 32'hA5A5_1234, 1'b0, '0);
    do_read(1); // R7: clean after correcting partial write
    do_write(2, 4'b1000, 32'hDEAD_BEEF, 1'b0, '0);
    do_write(2, 4'hF, 32'h0BAD_F00D, 1'b0, '0);
    do_read(2);

    do_write(3, 4'b0101, 32'h1122_3344, 1'b1, '0);
    do_read(4); // R9: poked full write to word 4 ignored
    do_read(3); // R4 lanes merged

    do_write(6, 4'hF, 32'hCAFE_0006, 1'b0, 39'h1 << 38);
    do_read(6); // R10: mask on the new codeword
    do_write(7, 4'b0000, 32'hFFFF_FFFF, 1'b0, '0);
    do_read(7);

    for (int k = 0; k < 400; k++) begin
      int a, op;
      a  = $urandom_range(NA - 1, 0);
      op = $urandom_range(9, 0);
      if (op < 4) do_read(a);
      else if (op < 6) do_write(a, 4'hF, $urandom, 1'b0, '0);
      else if (op < 8) do_write(a, 4'($urandom_range(14, 0)), $urandom, op == 7, '0);
      else if ($countones(m_flip[a]) < 2) begin
        do r = $urandom_range(38, 0); while (m_flip[a][r]);
        inject(a, 39'h1 << r);
      end else do_read(a);
    end
    finish_run();
  end
endmodule